// File: doc/BRIEF.md
# Converter Register Initialization Sequencer

This block runs on the FPGA side and brings an external high-speed converter out of reset after power-up. It talks to the converter over a four-wire serial register port: an active-low select, a serial clock, data toward the converter and data back from it. It waits until an external clock-ready input reports that the converter's sample and data clocks are running. No reset release and no register access can happen before the converter is clocked.

Once clock-ready is high, the block holds the converter reset low for a timed pulse and then waits a short gap. It then writes six registers in a fixed order. Next it reads each of those registers back in the same order and compares the value with what it wrote. Last it reads the converter's alarm register. Any difference, or a nonzero alarm word, sets the error flag and stores the offending address. A clean pass sets the done flag.

The states are WAIT_CLK, RESET, GAP, WRITE, VERIFY, ALARM, DONE and FAIL. The transitions are:
- WAIT_CLK to RESET when clock-ready is seen.
- RESET to GAP when the pulse count ends.
- GAP to WRITE when the gap count ends.
- WRITE to VERIFY after the sixth write frame.
- VERIFY to FAIL on a mismatch.
- VERIFY to ALARM after the sixth matching read.
- ALARM to DONE or FAIL, depending on the alarm word.
- Any state to WAIT_CLK when clock-ready drops.

The data-delay register takes one 3-bit delay input, `dly_sel`. The block copies it into both the upper-half field and the lower-half field, so that all fourteen data lines get the same delay.

Top module: `cis_init_seq`

## Requirements
- R1: While `clk_ready` is low, `conv_rst_n` is low and `spi_cs_n` is high, and no serial frame starts.
- R2: After `clk_ready` is sampled high, `conv_rst_n` stays low for exactly RST_US microseconds of system clock. With the defaults (100 MHz, 20 us) that is 2000 cycles. `spi_cs_n` stays high for the whole pulse, and the first frame starts only after `conv_rst_n` is high.
- R3: Write frames go out in this address order: 0x0A, 0x02, 0x03, 0x00, 0x14, 0x01.
- R4: The default write data is 0x0A=0xF0A0, 0x02=0x3FFF, 0x00=0x0284, 0x14=0x0100 and 0x01=0x3033.
- R5: The word written to 0x03 is 0x1C00 with `dly_sel` placed in bits 15:13 and again in bits 9:7.
- R6: Every frame is 24 bits, MSB first, framed by `spi_cs_n` low:
  - bit 23 is the direction, with 1 meaning read;
  - bits 22:16 are the address;
  - bits 15:0 are the data.

  `spi_sclk` idles low, and one full period is SCLK_DIV system clocks (default 8). `spi_mosi` changes only on a falling `spi_sclk` edge. `spi_miso` is sampled on a rising edge, and the last 16 samples form the read data.
- R7: After the writes, the six registers are read back in the same order. The first mismatch sets `init_err`, loads `fail_addr` with that register's address and stops the sequence with no further frames.
- R8: The last frame reads address 0x05. A nonzero value sets `init_err` with `fail_addr` = 0x05.
- R9: On a clean pass `init_done` goes high and `init_err` stays low. Flags and `fail_addr` are held with `spi_cs_n` high until a restart.
- R10: When `clk_ready` drops at any point, the block does the following:
  - it aborts any frame in progress (`spi_cs_n` goes high);
  - it drives `conv_rst_n` low;
  - it clears `init_done`, `init_err` and `fail_addr` one cycle later.

  The full sequence restarts when `clk_ready` returns.
- R11: `init_done` and `init_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| clk_ready | input | 1 | High while the converter's clocks are running |
| dly_sel | input | 3 | Data delay code mirrored into both delay fields |
| conv_rst_n | output | 1 | Active-low converter reset |
| spi_cs_n | output | 1 | Serial port select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| init_done | output | 1 | Sequence finished without error |
| init_err | output | 1 | Readback mismatch or nonzero alarm |
| fail_addr | output | 7 | Address that caused the error |

## Verification
The bench drives a behavioural converter model that decodes frames from the serial pins. A design that shifted LSB first, or changed data on the wrong edge, would therefore record wrong addresses and values. Mismatches are injected at the first, middle and last readback positions and the frame count is checked, so a sequencer that kept going after a failure, or blamed the wrong address, is caught. Several delay codes, including 0 and 7, would expose a mirror that put the code in only one field. Reset-pulse length, select activity before clock-ready, and an abort in the middle of the write list all target a block that touches the converter before its clocks run or fails to restart cleanly.

// File: rtl/cis_pkg.sv
package cis_pkg;
    localparam int FRAME_W = 24;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 7;
    localparam int N_WR    = 6;
    localparam int IDX_W   = $clog2(N_WR);

    localparam logic [ADDR_W-1:0] ALARM_ADDR = 7'h05;

    typedef enum logic [2:0] {
        ST_WAIT_CLK,
        ST_RESET,
        ST_GAP,
        ST_WRITE,
        ST_VERIFY,
        ST_ALARM,
        ST_DONE,
        ST_FAIL
    } seq_state_t;
endpackage

// File: rtl/cis_reg_table.sv
module cis_reg_table
    import cis_pkg::*;
#(
    parameter logic [DATA_W-1:0] V_0A   = 16'hF0A0,
    parameter logic [DATA_W-1:0] V_02   = 16'h3FFF,
    parameter logic [DATA_W-1:0] V_03   = 16'h1C00,
    parameter logic [DATA_W-1:0] V_00   = 16'h0284,
    parameter logic [DATA_W-1:0] V_14   = 16'h0100,
    parameter logic [DATA_W-1:0] V_01   = 16'h3033
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [2:0]        dly_sel,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] dly_word;

    // both delay fields carry the same code so every data line is aligned
    always_comb begin
        dly_word        = V_03;
        dly_word[15:13] = dly_sel;
        dly_word[9:7]   = dly_sel;
    end

    always_comb begin
        unique case (idx)
            3'd0:    begin addr = 7'h0A; data = V_0A;     end
            3'd1:    begin addr = 7'h02; data = V_02;     end
            3'd2:    begin addr = 7'h03; data = dly_word; end
            3'd3:    begin addr = 7'h00; data = V_00;     end
            3'd4:    begin addr = 7'h14; data = V_14;     end
            3'd5:    begin addr = 7'h01; data = V_01;     end
            default: begin addr = '0;    data = '0;       end
        endcase
    end
endmodule

// File: rtl/cis_spi_engine.sv
module cis_spi_engine
    import cis_pkg::*;
#(
    parameter int SCLK_DIV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh;
    logic [HW-1:0]      hcnt;
    logic [BW-1:0]      bitn;

    assign mosi = sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cs_n  <= 1'b1;
            sclk  <= 1'b0;
            sh    <= '0;
            hcnt  <= '0;
            bitn  <= '0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cs_n <= 1'b0;
                    sh   <= frame;
                    hcnt <= '0;
                    bitn <= '0;
                    sclk <= 1'b0;
                end
            end else if (hcnt == HW'(HALF - 1)) begin
                hcnt <= '0;
                if (!sclk) begin
                    if (bitn == BW'(FRAME_W)) begin
                        busy <= 1'b0;
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end else begin
                        sclk  <= 1'b1;
                        rdata <= {rdata[DATA_W-2:0], miso};
                    end
                end else begin
                    sclk <= 1'b0;
                    sh   <= {sh[FRAME_W-2:0], 1'b0};
                    bitn <= bitn + 1'b1;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R6: clock idles low outside a frame
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6: data toward the converter moves only on a falling serial clock
    p_mosi_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sclk));
endmodule

// File: rtl/cis_init_seq.sv
module cis_init_seq
    import cis_pkg::*;
#(
    parameter int                SYS_CLK_HZ = 100_000_000,
    parameter int                RST_US     = 20,
    parameter int                GAP_CYC    = 16,
    parameter int                SCLK_DIV   = 8,
    parameter logic [DATA_W-1:0] V_0A       = 16'hF0A0,
    parameter logic [DATA_W-1:0] V_02       = 16'h3FFF,
    parameter logic [DATA_W-1:0] V_03_BASE  = 16'h1C00,
    parameter logic [DATA_W-1:0] V_00       = 16'h0284,
    parameter logic [DATA_W-1:0] V_14       = 16'h0100,
    parameter logic [DATA_W-1:0] V_01       = 16'h3033
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_ready,
    input  logic [2:0]  dly_sel,
    output logic        conv_rst_n,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        init_done,
    output logic        init_err,
    output logic [6:0]  fail_addr
);
    localparam int RST_CYC = (SYS_CLK_HZ / 1_000_000) * RST_US;
    localparam int CNT_MAX = (RST_CYC > GAP_CYC) ? RST_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WR - 1);

    seq_state_t         state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic               launched;
    logic               eng_start, eng_busy, eng_done;
    logic [DATA_W-1:0]  eng_rdata;
    logic [ADDR_W-1:0]  tbl_addr;
    logic [DATA_W-1:0]  tbl_data;
    logic [FRAME_W-1:0] frame;
    logic               frame_state, mismatch, alarm_bad;

    cis_reg_table #(
        .V_0A(V_0A), .V_02(V_02), .V_03(V_03_BASE),
        .V_00(V_00), .V_14(V_14), .V_01(V_01)
    ) u_table (
        .idx(idx), .dly_sel(dly_sel), .addr(tbl_addr), .data(tbl_data)
    );

    cis_spi_engine #(.SCLK_DIV(SCLK_DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .abort(!clk_ready),
        .start(eng_start), .frame(frame),
        .busy(eng_busy), .done(eng_done), .rdata(eng_rdata),
        .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    assign frame_state = (state == ST_WRITE) || (state == ST_VERIFY) || (state == ST_ALARM);
    assign eng_start   = frame_state && !launched && !eng_busy;
    assign mismatch    = (eng_rdata != tbl_data);
    assign alarm_bad   = (eng_rdata != '0);
    assign conv_rst_n  = !((state == ST_WAIT_CLK) || (state == ST_RESET));

    always_comb begin
        unique case (state)
            ST_WRITE:  frame = {1'b0, tbl_addr, tbl_data};
            ST_VERIFY: frame = {1'b1, tbl_addr, {DATA_W{1'b0}}};
            ST_ALARM:  frame = {1'b1, ALARM_ADDR, {DATA_W{1'b0}}};
            default:   frame = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_CLK: if (clk_ready) nxt = ST_RESET;
            ST_RESET:    if (cnt == CNT_W'(RST_CYC - 1)) nxt = ST_GAP;
            ST_GAP:      if (cnt == CNT_W'(GAP_CYC - 1)) nxt = ST_WRITE;
            ST_WRITE:    if (eng_done && idx == LAST) nxt = ST_VERIFY;
            ST_VERIFY:   if (eng_done) begin
                             if (mismatch)         nxt = ST_FAIL;
                             else if (idx == LAST) nxt = ST_ALARM;
                         end
            ST_ALARM:    if (eng_done) nxt = alarm_bad ? ST_FAIL : ST_DONE;
            ST_DONE:     nxt = ST_DONE;
            ST_FAIL:     nxt = ST_FAIL;
            default:     nxt = ST_WAIT_CLK;
        endcase
        if (!clk_ready) nxt = ST_WAIT_CLK;
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT_CLK;
            cnt      <= '0;
            idx      <= '0;
            launched <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt      <= '0;
                idx      <= '0;
                launched <= 1'b0;
            end else begin
                if (state == ST_RESET || state == ST_GAP) cnt <= cnt + 1'b1;
                if (eng_done)       idx      <= idx + 1'b1;
                if (eng_done)       launched <= 1'b0;
                else if (eng_start) launched <= 1'b1;
            end
        end
    end

    // status outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !clk_ready) begin
            init_done <= 1'b0;
            init_err  <= 1'b0;
            fail_addr <= '0;
        end else if (eng_done) begin
            if (state == ST_VERIFY && mismatch) begin
                init_err  <= 1'b1;
                fail_addr <= tbl_addr;
            end else if (state == ST_ALARM) begin
                if (alarm_bad) begin
                    init_err  <= 1'b1;
                    fail_addr <= ALARM_ADDR;
                end else begin
                    init_done <= 1'b1;
                end
            end
        end
    end

    p_hold_until_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ready |=> (!conv_rst_n && spi_cs_n));

    p_no_access_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_rst_n |-> spi_cs_n);

    p_done_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && clk_ready) |=> init_done);

    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ready |=> (!init_done && !init_err && fail_addr == 7'h00));

    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && init_err));
endmodule

// File: tb/test_cis_init_seq.sv
module test_cis_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_RST    = 2000;   // 20 us at 100 MHz
    localparam int EXP_SCLK   = 8;

    typedef struct packed {
        logic [2:0]  dly;
        logic [6:0]  bad_addr;
        logic [15:0] alarm;
        logic        exp_err;
        logic [6:0]  exp_addr;
        logic [4:0]  exp_frames;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 7'h7F, 16'h0000, 1'b0, 7'h00, 5'd13},
        '{3'd5, 7'h7F, 16'h0000, 1'b0, 7'h00, 5'd13},
        '{3'd7, 7'h7F, 16'h0000, 1'b0, 7'h00, 5'd13},
        '{3'd2, 7'h03, 16'h0000, 1'b1, 7'h03, 5'd9},
        '{3'd1, 7'h0A, 16'h0000, 1'b1, 7'h0A, 5'd7},
        '{3'd3, 7'h01, 16'h0000, 1'b1, 7'h01, 5'd12},
        '{3'd0, 7'h7F, 16'h0010, 1'b1, 7'h05, 5'd13}
    };

    logic clk = 0, rst_n = 0, clk_ready = 0;
    logic [2:0] dly_sel = 0;
    logic conv_rst_n, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic init_done, init_err;
    logic [6:0] fail_addr;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cis_init_seq i_cis_init_seq (
        .clk(clk), .rst_n(rst_n), .clk_ready(clk_ready), .dly_sel(dly_sel),
        .conv_rst_n(conv_rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .init_done(init_done), .init_err(init_err), .fail_addr(fail_addr)
    );

    // behavioural converter register port
    logic [15:0] sregs [128];
    logic [15:0] alarm_val = 0;
    logic [6:0]  bad_addr = 7'h7F;
    logic [23:0] sin = 0;
    logic [15:0] sout = 0;
    logic [6:0]  wr_addr [16];
    logic [15:0] wr_val  [16];
    int scnt = 0, wr_cnt = 0, frames = 0, cs_falls = 0;
    bit srd = 0;

    initial begin
        spi_miso = 0;
        for (int i = 0; i < 128; i++) sregs[i] = 16'h0000;
    end

    always @(negedge spi_cs_n) begin scnt = 0; srd = 0; cs_falls++; end
    always @(posedge spi_sclk) if (!spi_cs_n) begin sin = {sin[22:0], spi_mosi}; scnt++; end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        if (scnt == 8 && sin[7]) begin
            srd  = 1;
            sout = (sin[6:0] == 7'h05) ? alarm_val : sregs[sin[6:0]];
            if (sin[6:0] == bad_addr) sout = sout ^ 16'h0001;
        end
        if (srd && scnt >= 8) begin spi_miso = sout[15]; sout = {sout[14:0], 1'b0}; end
    end
    always @(posedge spi_cs_n) if (scnt == 24) begin
        frames++;
        if (!sin[23]) begin
            sregs[sin[22:16]] = sin[15:0];
            if (wr_cnt < 16) begin wr_addr[wr_cnt] = sin[22:16]; wr_val[wr_cnt] = sin[15:0]; end
            wr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_addr_of(input int i);
        case (i)
            0: return 7'h0A; 1: return 7'h02; 2: return 7'h03;
            3: return 7'h00; 4: return 7'h14; default: return 7'h01;
        endcase
    endfunction

    function automatic logic [15:0] exp_val_of(input int i, input logic [2:0] d);
        case (i)
            0: return 16'hF0A0; 1: return 16'h3FFF;
            2: return 16'h1C00 | (16'(d) << 13) | (16'(d) << 7);   // R5
            3: return 16'h0284; 4: return 16'h0100; default: return 16'h3033;
        endcase
    endfunction

    task automatic restart(input logic [2:0] d, input logic [6:0] ba, input logic [15:0] al);
        @(negedge clk) clk_ready = 0;
        repeat (3) @(negedge clk);
        dly_sel = d; bad_addr = ba; alarm_val = al;
        wr_cnt = 0; frames = 0; cs_falls = 0;
        clk_ready = 1;
    endtask

    task automatic wait_end();
        int t = 0;
        while (!(init_done || init_err) && t < 20000) begin @(negedge clk); t++; end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1: reset state with clocks not ready
        chk(!conv_rst_n && spi_cs_n, "R1", "held in reset before ready", {conv_rst_n, spi_cs_n}, 2'b01);
        chk(!init_done && !init_err && fail_addr == 0, "R9", "flags clear after reset",
            {init_done, init_err, fail_addr}, 0);
        repeat (300) @(negedge clk);
        chk(cs_falls == 0 && !conv_rst_n, "R1", "no frame before ready", cs_falls, 0);

        // R2: reset pulse length, R6: serial clock period
        begin
            int n = 0; time t0;
            restart(3'd0, 7'h7F, 16'h0);
            do begin @(negedge clk); n++; end while (!conv_rst_n);
            chk(n - 1 == EXP_RST, "R2", "reset low cycles", n - 1, EXP_RST);
            chk(cs_falls == 0, "R2", "select idle during reset", cs_falls, 0);
            @(posedge spi_sclk) t0 = $time;
            @(posedge spi_sclk);
            chk(($time - t0) / CLK_PERIOD == EXP_SCLK, "R6", "sclk period",
                int'(($time - t0) / CLK_PERIOD), EXP_SCLK);
            wait_end();
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            vec_t x = VECS[v];
            int f0;
            restart(x.dly, x.bad_addr, x.alarm);
            wait_end();
            @(negedge clk);
            chk(init_err == x.exp_err, "R7", $sformatf("v%0d err flag", v), init_err, x.exp_err);
            chk(init_done == !x.exp_err, "R9", $sformatf("v%0d done flag", v), init_done, !x.exp_err);
            if (x.exp_err)
                chk(fail_addr == x.exp_addr, x.exp_addr == 7'h05 ? "R8" : "R7",
                    $sformatf("v%0d fail addr", v), fail_addr, x.exp_addr);
            chk(wr_cnt == 6, "R3", $sformatf("v%0d write count", v), wr_cnt, 6);
            for (int i = 0; i < 6; i++) begin
                chk(wr_addr[i] == exp_addr_of(i), "R3", $sformatf("v%0d write %0d addr", v, i),
                    wr_addr[i], exp_addr_of(i));
                chk(wr_val[i] == exp_val_of(i, x.dly), i == 2 ? "R5" : "R4",
                    $sformatf("v%0d write %0d data", v, i), wr_val[i], exp_val_of(i, x.dly));
            end
            f0 = frames;
            repeat (200) @(negedge clk);
            chk(frames == int'(x.exp_frames) && frames == f0, "R7", $sformatf("v%0d frame total", v),
                frames, x.exp_frames);
            chk((init_done || init_err) && spi_cs_n, "R9", $sformatf("v%0d flags held", v),
                {init_done, init_err, spi_cs_n}, 1);
            chk(!(init_done && init_err), "R11", $sformatf("v%0d exclusive flags", v),
                {init_done, init_err}, 0);
        end

        // R10: loss of clocks after an error clears status
        @(negedge clk) clk_ready = 0;
        @(negedge clk);
        chk(!init_err && fail_addr == 0 && !conv_rst_n, "R10", "clear after error",
            {init_err, fail_addr}, 0);

        // R10: abort in the middle of the write list, then clean restart
        restart(3'd4, 7'h7F, 16'h0);
        while (wr_cnt < 2) @(negedge clk);
        repeat (20) @(negedge clk);
        clk_ready = 0;
        @(negedge clk);
        chk(spi_cs_n && !conv_rst_n && !init_done, "R10", "abort mid frame",
            {spi_cs_n, conv_rst_n, init_done}, 3'b100);
        restart(3'd4, 7'h7F, 16'h0);
        wait_end();
        @(negedge clk);
        chk(init_done && !init_err && wr_cnt == 6, "R10", "restart completes",
            {init_done, init_err}, 2'b10);
        chk(wr_addr[0] == 7'h0A, "R10", "restart begins at list head", wr_addr[0], 7'h0A);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule